// File: doc/BRIEF.md
# Banked Data Register File

This block is the byte-wide data store of a small 8-bit controller core. It holds four banks of 128 locations each. The low offsets of every bank are set aside for special registers, general-purpose bytes sit above them, and the top sixteen offsets form one region that every bank shares. A chosen set of special-register offsets is kept once, in bank 0, and every other bank sees that same byte at the same offset. Special offsets that are neither mirrored nor marked as implemented do not exist: they read as zero and ignore writes.

The core reaches the store in two ways. A direct access gives a 7-bit offset, and the bank comes from two bank-select bits. An indirect access gives an 8-bit pointer, and one extra bank bit forms the top of the 9-bit address. The read side and the write side each choose their own mode and address, and both use the same status bits. Writes take effect on the clock edge. Reads are combinational.

Top module: `bkrf_top`

## Requirements
- R1: A direct access (mode bit 0) addresses bank `bank_sel[1:0]` at offset `off[6:0]`. The 9-bit address is {bank_sel, off}.
- R2: An indirect access (mode bit 1) forms the 9-bit address {ind_bank, ptr[7:0]}, so the bank is {ind_bank, ptr[7]} and the offset is ptr[6:0].
- R3: Offsets 70h–7Fh are one shared set of 16 bytes. A write there through any bank is read back through all four banks.
- R4: The mirrored special offsets (default 00h, 02h, 03h, 04h, 0Ah, 0Bh) are stored once. A write through any bank is seen at the same offset in every bank.
- R5: General-purpose offsets 20h–6Fh hold a separate byte in each bank.
- R6: Unimplemented special offsets (default 07h–09h and 10h–1Fh) always read 00h in every bank.
- R7: A write to an unimplemented offset changes no readable location.
- R8: A write with `wr_en`=1 takes effect at the rising clock edge, and a read of that address in the next cycle returns the new byte. With `wr_en`=0 no location changes.
- R9: After reset every location reads 00h.
- R10: Implemented special offsets that are not mirrored (default 01h, 05h, 06h, 0Ch–0Fh) hold a separate byte in each bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Bank bits used by direct accesses |
| ind_bank | input | 1 | Upper address bit used by indirect accesses |
| rd_ind | input | 1 | Read mode: 0 direct, 1 indirect |
| rd_off | input | 7 | Direct read offset |
| rd_ptr | input | 8 | Indirect read pointer |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_ind | input | 1 | Write mode: 0 direct, 1 indirect |
| wr_off | input | 7 | Direct write offset |
| wr_ptr | input | 8 | Indirect write pointer |
| wr_data | input | 8 | Write data |

## Verification
Reads are combinational, so a wrong alias decision or a flop that holds bad contents shows on `rd_data` in the same cycle the location is read. A write that lands in the wrong physical byte shows up on the first read, through any bank, of either the intended location or the location that was hit by mistake. The bench keeps a behavioural image of all 512 logical locations, in which each aliased write is copied to every bank. It compares this image with `rd_data` in every cycle, under directed alias tests and under random traffic in both modes, so a fault in any alias class is caught on the first cycle that reads it.

// File: rtl/bkrf_pkg.sv
`timescale 1ns/1ps
package bkrf_pkg;
  typedef enum logic [1:0] {
    RGN_SPECIAL = 2'd0,
    RGN_GENERAL = 2'd1,
    RGN_SHARED  = 2'd2
  } bkrf_region_e;

  localparam int unsigned DEF_BANK_BITS    = 2;
  localparam int unsigned DEF_OFF_W        = 7;
  localparam int unsigned DEF_DATA_W       = 8;
  localparam int unsigned DEF_SHARED_BYTES = 16;
  localparam int unsigned DEF_SFR_COUNT    = 32;
  // offsets 00h,02h,03h,04h,0Ah,0Bh kept once in bank 0
  localparam logic [31:0] DEF_MIRROR_MASK  = 32'h0000_0C1D;
  // offsets 01h,05h,06h,0Ch-0Fh present in every bank
  localparam logic [31:0] DEF_IMPL_MASK    = 32'h0000_F062;
endpackage

// File: rtl/bkrf_addr_gen.sv
`timescale 1ns/1ps
module bkrf_addr_gen #(
  parameter int unsigned BANK_BITS = 2,
  parameter int unsigned OFF_W     = 7,
  localparam int unsigned ADDR_W   = BANK_BITS + OFF_W,
  localparam int unsigned PTR_W    = OFF_W + BANK_BITS - 1
) (
  input  logic                 ind,
  input  logic [BANK_BITS-1:0] bank_sel,
  input  logic                 ind_bank,
  input  logic [OFF_W-1:0]     off,
  input  logic [PTR_W-1:0]     ptr,
  output logic [ADDR_W-1:0]    eff
);
  always_comb begin
    if (ind) begin
      eff = {ind_bank, ptr};
    end else begin
      eff = {bank_sel, off};
    end
  end
endmodule

// File: rtl/bkrf_alias_map.sv
`timescale 1ns/1ps
module bkrf_alias_map
  import bkrf_pkg::*;
#(
  parameter int unsigned BANK_BITS    = 2,
  parameter int unsigned OFF_W        = 7,
  parameter int unsigned SHARED_BYTES = 16,
  parameter int unsigned SFR_COUNT    = 32,
  parameter logic [SFR_COUNT-1:0] MIRROR_MASK = '0,
  parameter logic [SFR_COUNT-1:0] IMPL_MASK   = '0,
  localparam int unsigned ADDR_W      = BANK_BITS + OFF_W,
  localparam int unsigned BANK_BYTES  = 1 << OFF_W,
  localparam int unsigned SHARED_BASE = BANK_BYTES - SHARED_BYTES,
  localparam int unsigned SFR_IW      = (SFR_COUNT > 1) ? $clog2(SFR_COUNT) : 1
) (
  input  logic [ADDR_W-1:0] eff,
  output logic              impl,
  output logic [ADDR_W-1:0] idx,
  output bkrf_region_e      region
);
  logic [OFF_W-1:0]  off;
  logic [SFR_IW-1:0] sfr_sel;

  assign off     = eff[OFF_W-1:0];
  assign sfr_sel = off[SFR_IW-1:0];

  always_comb begin
    if (32'(off) >= SHARED_BASE) begin
      region = RGN_SHARED;
      impl   = 1'b1;
      idx    = {{BANK_BITS{1'b0}}, off};
    end else if (32'(off) < SFR_COUNT) begin
      region = RGN_SPECIAL;
      if (MIRROR_MASK[sfr_sel]) begin
        impl = 1'b1;
        idx  = {{BANK_BITS{1'b0}}, off};
      end else begin
        impl = IMPL_MASK[sfr_sel];
        idx  = eff;
      end
    end else begin
      region = RGN_GENERAL;
      impl   = 1'b1;
      idx    = eff;
    end
  end
endmodule

// File: rtl/bkrf_store.sv
`timescale 1ns/1ps
module bkrf_store #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic              cell_en;
    logic [DATA_W-1:0] cell_d;

    always_comb begin
      cell_en = we && (wr_idx == ADDR_W'(gi));
      cell_d  = cell_en ? wr_data : cell_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[gi] <= '0;
      end else begin
        cell_q[gi] <= cell_d;
      end
    end
  end

  assign rd_q = cell_q[rd_idx];
endmodule

// File: rtl/bkrf_top.sv
`timescale 1ns/1ps
module bkrf_top
  import bkrf_pkg::*;
#(
  parameter int unsigned BANK_BITS    = DEF_BANK_BITS,
  parameter int unsigned OFF_W        = DEF_OFF_W,
  parameter int unsigned DATA_W       = DEF_DATA_W,
  parameter int unsigned SHARED_BYTES = DEF_SHARED_BYTES,
  parameter int unsigned SFR_COUNT    = DEF_SFR_COUNT,
  parameter logic [SFR_COUNT-1:0] MIRROR_MASK = DEF_MIRROR_MASK[SFR_COUNT-1:0],
  parameter logic [SFR_COUNT-1:0] IMPL_MASK   = DEF_IMPL_MASK[SFR_COUNT-1:0],
  localparam int unsigned ADDR_W = BANK_BITS + OFF_W,
  localparam int unsigned PTR_W  = OFF_W + BANK_BITS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BANK_BITS-1:0] bank_sel,
  input  logic                 ind_bank,
  input  logic                 rd_ind,
  input  logic [OFF_W-1:0]     rd_off,
  input  logic [PTR_W-1:0]     rd_ptr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 wr_en,
  input  logic                 wr_ind,
  input  logic [OFF_W-1:0]     wr_off,
  input  logic [PTR_W-1:0]     wr_ptr,
  input  logic [DATA_W-1:0]    wr_data
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [ADDR_W-1:0] rd_eff, wr_eff, rd_idx, wr_idx;
  logic              rd_impl, wr_impl;
  bkrf_region_e      rd_rgn, wr_rgn;
  logic [DATA_W-1:0] rd_q;
  logic              store_we;

  bkrf_addr_gen #(.BANK_BITS(BANK_BITS), .OFF_W(OFF_W)) i_rd_addr (
    .ind(rd_ind), .bank_sel(bank_sel), .ind_bank(ind_bank),
    .off(rd_off), .ptr(rd_ptr), .eff(rd_eff)
  );

  bkrf_addr_gen #(.BANK_BITS(BANK_BITS), .OFF_W(OFF_W)) i_wr_addr (
    .ind(wr_ind), .bank_sel(bank_sel), .ind_bank(ind_bank),
    .off(wr_off), .ptr(wr_ptr), .eff(wr_eff)
  );

  bkrf_alias_map #(
    .BANK_BITS(BANK_BITS), .OFF_W(OFF_W), .SHARED_BYTES(SHARED_BYTES),
    .SFR_COUNT(SFR_COUNT), .MIRROR_MASK(MIRROR_MASK), .IMPL_MASK(IMPL_MASK)
  ) i_rd_map (.eff(rd_eff), .impl(rd_impl), .idx(rd_idx), .region(rd_rgn));

  bkrf_alias_map #(
    .BANK_BITS(BANK_BITS), .OFF_W(OFF_W), .SHARED_BYTES(SHARED_BYTES),
    .SFR_COUNT(SFR_COUNT), .MIRROR_MASK(MIRROR_MASK), .IMPL_MASK(IMPL_MASK)
  ) i_wr_map (.eff(wr_eff), .impl(wr_impl), .idx(wr_idx), .region(wr_rgn));

  // region tags are kept for the checker; unused by the datapath
  logic unused_rgn;
  assign unused_rgn = ^{rd_rgn, wr_rgn};

  assign store_we = wr_en && wr_impl;

  bkrf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_sync_n), .we(store_we), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_q(rd_q)
  );

  assign rd_data = rd_impl ? rd_q : '0;
endmodule

// File: rtl/bkrf_chk.sv
`timescale 1ns/1ps
module bkrf_chk #(
  parameter int unsigned BANK_BITS    = 2,
  parameter int unsigned OFF_W        = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SHARED_BYTES = 16,
  parameter int unsigned SFR_COUNT    = 32,
  parameter logic [SFR_COUNT-1:0] MIRROR_MASK = '0,
  parameter logic [SFR_COUNT-1:0] IMPL_MASK   = '0,
  localparam int unsigned ADDR_W = BANK_BITS + OFF_W,
  localparam int unsigned PTR_W  = OFF_W + BANK_BITS - 1,
  localparam int unsigned SHARED_BASE = (1 << OFF_W) - SHARED_BYTES,
  localparam int unsigned SFR_IW = (SFR_COUNT > 1) ? $clog2(SFR_COUNT) : 1
) (
  input logic                 clk,
  input logic                 rst_ok,
  input logic [BANK_BITS-1:0] bank_sel,
  input logic                 ind_bank,
  input logic                 rd_ind,
  input logic [OFF_W-1:0]     rd_off,
  input logic [PTR_W-1:0]     rd_ptr,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 wr_en,
  input logic                 wr_ind,
  input logic [OFF_W-1:0]     wr_off,
  input logic [PTR_W-1:0]     wr_ptr,
  input logic [DATA_W-1:0]    wr_data
);
  logic [ADDR_W-1:0] r_a, w_a;
  logic [OFF_W-1:0]  r_o, w_o;
  logic              r_unimpl, w_mirror, w_shared, w_exists;

  assign r_a = rd_ind ? {ind_bank, rd_ptr} : {bank_sel, rd_off};
  assign w_a = wr_ind ? {ind_bank, wr_ptr} : {bank_sel, wr_off};
  assign r_o = r_a[OFF_W-1:0];
  assign w_o = w_a[OFF_W-1:0];

  assign r_unimpl = (32'(r_o) < SFR_COUNT) && !MIRROR_MASK[r_o[SFR_IW-1:0]]
                    && !IMPL_MASK[r_o[SFR_IW-1:0]];
  assign w_mirror = (32'(w_o) < SFR_COUNT) && MIRROR_MASK[w_o[SFR_IW-1:0]];
  assign w_shared = 32'(w_o) >= SHARED_BASE;
  assign w_exists = !((32'(w_o) < SFR_COUNT) && !MIRROR_MASK[w_o[SFR_IW-1:0]]
                    && !IMPL_MASK[w_o[SFR_IW-1:0]]);

  // R6
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    r_unimpl |-> (rd_data == '0));

  // R8
  write_seen_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && w_exists && (w_a == r_a)) |=>
      (!$stable(r_a) || (rd_data == $past(wr_data))));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en |=> (!$stable(r_a) || $stable(rd_data)));

  // R3
  shared_alias_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && w_shared) |=>
      ((r_o != $past(w_o)) || (rd_data == $past(wr_data))));

  // R4
  mirror_alias_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && w_mirror) |=>
      ((r_o != $past(w_o)) || (rd_data == $past(wr_data))));
endmodule

bind bkrf_top bkrf_chk #(
  .BANK_BITS(BANK_BITS), .OFF_W(OFF_W), .DATA_W(DATA_W),
  .SHARED_BYTES(SHARED_BYTES), .SFR_COUNT(SFR_COUNT),
  .MIRROR_MASK(MIRROR_MASK), .IMPL_MASK(IMPL_MASK)
) i_bkrf_chk (
  .clk(clk), .rst_ok(rst_sync_n), .bank_sel(bank_sel), .ind_bank(ind_bank),
  .rd_ind(rd_ind), .rd_off(rd_off), .rd_ptr(rd_ptr), .rd_data(rd_data),
  .wr_en(wr_en), .wr_ind(wr_ind), .wr_off(wr_off), .wr_ptr(wr_ptr),
  .wr_data(wr_data)
);

// File: tb/test_bkrf_top.sv
`timescale 1ns/1ps
module test_bkrf_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bank_sel;
  logic       ind_bank, rd_ind, wr_en, wr_ind;
  logic [6:0] rd_off, wr_off;
  logic [7:0] rd_ptr, wr_ptr, wr_data, rd_data;

  always #2.5 clk = ~clk;

  bkrf_top i_bkrf_top (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .ind_bank(ind_bank),
    .rd_ind(rd_ind), .rd_off(rd_off), .rd_ptr(rd_ptr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_ind(wr_ind), .wr_off(wr_off), .wr_ptr(wr_ptr),
    .wr_data(wr_data)
  );

  int    n_run = 0;
  int    n_fail = 0;
  bit    checking = 0;
  bit    finished = 0;
  string tag = "R9";
  logic [7:0] img [512];

  // address classes taken from the requirements
  function automatic bit is_mirror(int o);
    return o == 'h00 || o == 'h02 || o == 'h03 || o == 'h04 || o == 'h0A || o == 'h0B;
  endfunction
  function automatic bit is_unimpl(int o);
    return (o >= 'h07 && o <= 'h09) || (o >= 'h10 && o <= 'h1F);
  endfunction
  function automatic bit is_shared(int o);
    return o >= 'h70;
  endfunction

  function automatic int rd_bank();
    return rd_ind ? int'({ind_bank, rd_ptr[7]}) : int'(bank_sel);
  endfunction
  function automatic int rd_o();
    return rd_ind ? int'(rd_ptr[6:0]) : int'(rd_off);
  endfunction

  function automatic logic [7:0] expect_rd();
    if (is_unimpl(rd_o())) return 8'h00;
    return img[rd_bank()*128 + rd_o()];
  endfunction

  // image update, one copy per logical location
  always @(posedge clk) begin
    if (checking && wr_en) begin
      automatic int b = wr_ind ? int'({ind_bank, wr_ptr[7]}) : int'(bank_sel);
      automatic int o = wr_ind ? int'(wr_ptr[6:0]) : int'(wr_off);
      if (is_shared(o) || is_mirror(o)) begin
        for (int k = 0; k < 4; k++) img[k*128 + o] = wr_data;
      end else if (!is_unimpl(o)) begin
        img[b*128 + o] = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      n_run++;
      if (rd_data !== expect_rd()) begin
        n_fail++;
        $display("FAIL %s bank%0d off %02h: actual %02h expected %02h",
                 tag, rd_bank(), rd_o(), rd_data, expect_rd());
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic wr_dir(int b, int o, int d);
    bank_sel = 2'(b); wr_ind = 0; wr_off = 7'(o); wr_data = 8'(d); wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd_dir(int b, int o);
    bank_sel = 2'(b); rd_ind = 0; rd_off = 7'(o);
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) img[i] = 8'h00;
    rst_n = 0; bank_sel = 0; ind_bank = 0; rd_ind = 0; rd_off = 0; rd_ptr = 0;
    wr_en = 0; wr_ind = 0; wr_off = 0; wr_ptr = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1 checking = 1;

    tag = "R9";
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 128; o += 7) rd_dir(b, o);

    tag = "R1";
    for (int b = 0; b < 4; b++) wr_dir(b, 'h30, 'h10 + b);
    tag = "R5";
    for (int b = 0; b < 4; b++) rd_dir(b, 'h30);
    wr_dir(2, 'h6F, 'h5C); rd_dir(0, 'h6F); rd_dir(2, 'h6F);

    tag = "R10";
    for (int b = 0; b < 4; b++) wr_dir(b, 'h01, 'hA0 + b);
    for (int b = 0; b < 4; b++) rd_dir(b, 'h01);
    wr_dir(3, 'h0F, 'h3C); rd_dir(1, 'h0F); rd_dir(3, 'h0F);

    tag = "R3";
    wr_dir(2, 'h75, 'hC3);
    for (int b = 0; b < 4; b++) rd_dir(b, 'h75);
    wr_dir(0, 'h7F, 'h99); rd_dir(3, 'h7F); rd_dir(1, 'h70);

    tag = "R4";
    wr_dir(3, 'h03, 'h5A);
    for (int b = 0; b < 4; b++) rd_dir(b, 'h03);
    wr_dir(1, 'h0B, 'h77); rd_dir(0, 'h0B); rd_dir(2, 'h0B);

    tag = "R6";
    for (int b = 0; b < 4; b++) rd_dir(b, 'h08);
    tag = "R7";
    wr_dir(1, 'h07, 'hAA); rd_dir(1, 'h07); rd_dir(1, 'h06); rd_dir(1, 'h08);
    wr_dir(0, 'h1F, 'hFF); rd_dir(0, 'h1F); rd_dir(0, 'h20);

    tag = "R2";
    ind_bank = 1; wr_ind = 1; wr_ptr = 8'hB0; wr_data = 8'h4E; wr_en = 1;
    idle(); wr_en = 0; wr_ind = 0;
    rd_dir(3, 'h30); rd_dir(2, 'h30);
    rd_ind = 1; ind_bank = 0; rd_ptr = 8'hB0; idle();
    ind_bank = 1; rd_ptr = 8'h30; idle(); rd_ind = 0;

    tag = "R8";
    bank_sel = 2; rd_off = 7'h40; wr_off = 7'h40; wr_ind = 0; wr_data = 8'hE1;
    wr_en = 1; idle(); wr_en = 0; wr_data = 8'h00; idle(); idle();

    for (int i = 0; i < 3000; i++) begin
      bank_sel = 2'($urandom); ind_bank = 1'($urandom);
      rd_ind = 1'($urandom); rd_off = 7'($urandom); rd_ptr = 8'($urandom);
      wr_ind = 1'($urandom); wr_off = 7'($urandom); wr_ptr = 8'($urandom);
      wr_data = 8'($urandom); wr_en = 1'($urandom);
      if (i % 4 == 0) begin rd_off = wr_off; rd_ind = wr_ind; rd_ptr = wr_ptr; end
      idle();
    end
    wr_en = 0; idle();
    checking = 0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule